// File: doc/BRIEF.md
# Packed mixed-sign saturating byte adder

This block adds two 32-bit words as four independent 8-bit lanes. In each lane the byte from operand A is a two's-complement signed value and the byte from operand B is an unsigned value. The lane result is unsigned. When the true sum is above 255 the lane is clamped to 255, and when it is below zero the lane is clamped to 0. It serves scoring kernels that add a signed penalty or bonus to an unsigned score byte and need the score to stay inside the byte range.

The adder forms the low seven bits of every lane in one word-wide addition with the lane top bits masked off, so no carry can leave its lane. It then rebuilds each lane's top bit and its carry-out from the sign of A, the top bit of B and the carry into bit 7. The carry-out and the sign of A select saturation to all-ones or to zero. The packed result and per-lane high and low clamp flags are registered when the input strobe is high. The output valid follows the input strobe one cycle later.

Top module: `sus_byte_adder`

## Requirements
- R1: Lane k occupies bits 8k+7..8k of each word, and of the result, for k = 0..3. No carry or borrow from one lane changes any other lane's result.
- R2: When signed(A lane) + unsigned(B lane) lies in 0..255, the result lane equals that sum exactly, and both clamp flags of the lane are 0.
- R3: When the lane sum exceeds 255, the result lane is 0xFF and high-clamp flag bit k of `hi_clamp_o` is 1.
- R4: When the lane sum is below 0, the result lane is 0x00 and low-clamp flag bit k of `lo_clamp_o` is 1.
- R5: The high and low clamp flags of a lane are never 1 together.
- R6: Result and flags are captured on the rising clock edge at which `in_valid_i` is 1. `out_valid_o` equals `in_valid_i` from the previous edge.
- R7: While `in_valid_i` is 0 at an edge, the result and both flag words hold their previous values.
- R8: Asserting `rst_ni` low clears `out_valid_o`, the result and both flag words to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid, capture strobe |
| opa_i | input | 32 | Four signed bytes |
| opb_i | input | 32 | Four unsigned bytes |
| out_valid_o | output | 1 | Registered result valid |
| sum_o | output | 32 | Four saturated unsigned bytes |
| hi_clamp_o | output | 4 | Per-lane clamp to 255 flag |
| lo_clamp_o | output | 4 | Per-lane clamp to 0 flag |

## Verification
The bench targets the lane edges: 0x80 plus 0x00 (most negative plus zero, must give 0 with a low clamp), 0x7F plus 0xFF (the largest overflow, must give 255), 0xFF plus 0x00 (-1 must clamp, while a design that treats A as unsigned returns 255), and 0x80 plus 0x80 (exactly zero, which a design that confuses the carry-out with the sign would clamp wrongly). Words in which every lane carries out test isolation, because a leaking carry shows up as an off-by-one in the next lane. Over 100000 random pairs, with random strobe gaps, a cycle model finds wrong flags, a result that changes while the strobe is low, and valid-delay errors.

// File: rtl/sus_pkg.sv
package sus_pkg;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_LANE_W = 8;

  typedef struct packed {
    logic hi;
    logic lo;
  } clamp_t;
endpackage

// File: rtl/sus_low_adder.sv
// Word-wide add of every lane's low bits; lane top bits are zeroed so the
// carry into each lane top lands in that bit and never propagates further.
module sus_low_adder #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] opb_i,
  output logic [WORD_W-1:0] low_sum_o
);
  logic [WORD_W-1:0] low_mask;

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign low_mask[k*LANE_W +: LANE_W] = {1'b0, {(LANE_W-1){1'b1}}};
  end

  assign low_sum_o = (opa_i & low_mask) + (opb_i & low_mask);
endmodule

// File: rtl/sus_lane_fix.sv
// Rebuilds one lane's top bit and carry-out, then derives the clamp flags.
module sus_lane_fix
  import sus_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic              a_top_i,
  input  logic              b_top_i,
  input  logic [LANE_W-1:0] low_lane_i,
  output logic [LANE_W-1:0] raw_o,
  output clamp_t            clamp_o
);
  logic c_in_top;
  logic c_out;

  assign c_in_top = low_lane_i[LANE_W-1];
  assign raw_o    = {a_top_i ^ b_top_i ^ c_in_top, low_lane_i[LANE_W-2:0]};
  assign c_out    = (a_top_i & b_top_i) | ((a_top_i ^ b_top_i) & c_in_top);
  // value = raw + 2^W * (c_out - a_top)
  assign clamp_o.hi = c_out & ~a_top_i;
  assign clamp_o.lo = a_top_i & ~c_out;
endmodule

// File: rtl/sus_sat_mask.sv
module sus_sat_mask
  import sus_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] raw_i,
  input  clamp_t            clamp_i,
  output logic [LANE_W-1:0] sat_o
);
  logic [LANE_W-1:0] hi_mask;
  logic [LANE_W-1:0] lo_mask;

  assign hi_mask = {LANE_W{clamp_i.hi}};
  assign lo_mask = {LANE_W{clamp_i.lo}};
  assign sat_o   = (raw_i | hi_mask) & ~lo_mask;
endmodule

// File: rtl/sus_byte_adder.sv
module sus_byte_adder
  import sus_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] opb_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] sum_o,
  output logic [LANES-1:0]  hi_clamp_o,
  output logic [LANES-1:0]  lo_clamp_o
);
  logic [WORD_W-1:0] low_sum;
  logic [WORD_W-1:0] sat_word;
  logic [LANES-1:0]  lane_hi;
  logic [LANES-1:0]  lane_lo;

  sus_low_adder #(.LANES(LANES), .LANE_W(LANE_W)) u_low (
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .low_sum_o (low_sum)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned TOP = k*LANE_W + LANE_W - 1;
    logic [LANE_W-1:0] raw;
    clamp_t            clamp;

    sus_lane_fix #(.LANE_W(LANE_W)) u_fix (
      .a_top_i    (opa_i[TOP]),
      .b_top_i    (opb_i[TOP]),
      .low_lane_i (low_sum[k*LANE_W +: LANE_W]),
      .raw_o      (raw),
      .clamp_o    (clamp)
    );

    sus_sat_mask #(.LANE_W(LANE_W)) u_sat (
      .raw_i   (raw),
      .clamp_i (clamp),
      .sat_o   (sat_word[k*LANE_W +: LANE_W])
    );

    assign lane_hi[k] = clamp.hi;
    assign lane_lo[k] = clamp.lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      hi_clamp_o  <= '0;
      lo_clamp_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sum_o      <= sat_word;
        hi_clamp_o <= lane_hi;
        lo_clamp_o <= lane_lo;
      end
    end
  end
endmodule

// File: rtl/sus_byte_adder_chk.sv
module sus_byte_adder_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic [WORD_W-1:0] sum_o,
  input logic [LANES-1:0]  hi_clamp_o,
  input logic [LANES-1:0]  lo_clamp_o,
  input logic [LANES-1:0]  lane_hi,
  input logic [LANES-1:0]  lane_lo
);
  AST_LANE_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_hi & lane_lo) == '0); // R5
  AST_OUT_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_clamp_o & lo_clamp_o) == '0); // R5
  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i)); // R6
  AST_CAPTURE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (hi_clamp_o == $past(lane_hi)) && (lo_clamp_o == $past(lane_lo))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(sum_o) && $stable(hi_clamp_o) && $stable(lo_clamp_o)); // R7

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    AST_HI_IS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_clamp_o[k] |-> sum_o[k*LANE_W +: LANE_W] == {LANE_W{1'b1}}); // R3
    AST_LO_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_clamp_o[k] |-> sum_o[k*LANE_W +: LANE_W] == '0); // R4
  end
endmodule

bind sus_byte_adder sus_byte_adder_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .sum_o       (sum_o),
  .hi_clamp_o  (hi_clamp_o),
  .lo_clamp_o  (lo_clamp_o),
  .lane_hi     (lane_hi),
  .lane_lo     (lane_lo)
);

// File: tb/sus_byte_adder_test.sv
`timescale 1ns/1ps
module sus_byte_adder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        out_valid_o;
  logic [31:0] sum_o;
  logic [3:0]  hi_clamp_o;
  logic [3:0]  lo_clamp_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] e_sum = '0;
  logic [3:0]  e_hi = '0, e_lo = '0;
  logic        e_vld = 1'b0;
  string       tag = "R2";

  always #5 clk_i = ~clk_i;

  sus_byte_adder uut (.*);

  function automatic int lane_total(logic [31:0] a, logic [31:0] b, int k);
    int sa;
    sa = int'($signed(a[k*8 +: 8]));
    return sa + int'(b[k*8 +: 8]);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R6", "out_valid", out_valid_o, e_vld);
    for (int k = 0; k < 4; k++) begin
      string r;
      r = e_hi[k] ? "R3" : (e_lo[k] ? "R4" : tag);
      chk(r, $sformatf("lane%0d", k), sum_o[k*8 +: 8], e_sum[k*8 +: 8]);
    end
    chk("R3", "hi_clamp", hi_clamp_o, e_hi);
    chk("R4", "lo_clamp", lo_clamp_o, e_lo);
    chk("R5", "flag overlap", hi_clamp_o & lo_clamp_o, 0);
  endtask

  task automatic drive(bit v, logic [31:0] a, logic [31:0] b);
    in_valid_i = v;
    opa_i = a;
    opb_i = b;
    e_vld = v;
    if (v) begin
      for (int k = 0; k < 4; k++) begin
        int t;
        t = lane_total(a, b, k);
        e_hi[k] = t > 255;
        e_lo[k] = t < 0;
        e_sum[k*8 +: 8] = (t > 255) ? 8'hFF : ((t < 0) ? 8'h00 : 8'(t));
      end
    end
  endtask

  task automatic step(bit v, logic [31:0] a, logic [31:0] b);
    drive(v, a, b);
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    compare(); // R8 state under reset
    chk("R8", "reset valid", out_valid_o, 0);
    chk("R8", "reset sum", sum_o, 0);
    rst_ni = 1'b1;
    // corner lanes: -128+0, 127+255, -1+0, -128+128
    tag = "R2";
    step(1, 32'h80_7F_FF_80, 32'h80_FF_00_00);
    step(1, 32'h7F_80_80_FF, 32'h00_80_00_FF);
    step(1, 32'h01_FF_00_80, 32'hFE_FF_FF_7F);
    // R1: every lane produces a carry-out; neighbours must stay intact
    tag = "R1";
    step(1, 32'h7F_01_FF_7F, 32'h81_FF_01_81);
    step(1, 32'h40_C0_3F_FF, 32'hC0_40_C1_01);
    // R7: strobe low, outputs must hold
    tag = "R7";
    step(0, 32'hDEAD_BEEF, 32'h1234_5678);
    step(0, 32'h7F7F_7F7F, 32'hFFFF_FFFF);
    // R8: mid-run asynchronous reset
    step(1, 32'h7F7F_7F7F, 32'hFFFF_FFFF);
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    e_vld = 0; e_sum = '0; e_hi = '0; e_lo = '0;
    chk("R8", "async valid", out_valid_o, 0);
    chk("R8", "async sum", sum_o, 0);
    chk("R8", "async flags", {hi_clamp_o, lo_clamp_o}, 0);
    @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    tag = "R2";
    for (int i = 0; i < 100000; i++) begin
      step(($urandom % 8) != 0, $urandom, $urandom);
    end
    step(0, '0, '0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule